// File: doc/BRIEF.md
# Function Configuration Space Register File

This block holds the 256-byte configuration image of a single bus function and serves configuration reads and writes to it. Each access presents a 24-bit configuration address (bus number in bits 23:16, device/function number in bits 15:8, register offset in bits 7:0), a length code and, for writes, 32 bits of little-endian write data. Accesses whose bus or device/function field does not select this function fall through: reads return all ones and writes leave the image unchanged.

Writes are filtered one byte at a time through a read-only map. The map depends on the header layout chosen at elaboration: an ordinary endpoint layout or a bridge layout. Full-width writes into the base address windows are forced to the region's size alignment, with the region's type bits kept, so that writing all ones and reading back yields the sizing mask. The block pulses a remap request whenever the command register or a base address value actually changes. On a bridge it also exposes the stored secondary bus number to the routing logic.

Top module: `cfg_space_regfile`

## Requirements
- R1: An access hits only when address bits 23:16 equal BUS_NUM and bits 15:8 equal DEVFN. A missed read returns 0x000000FF for length code 1, 0x0000FFFF for length code 2 and 0xFFFFFFFF otherwise. A missed write changes no byte.
- R2: A read returns its data on rd_data with rd_valid high in the cycle after acc_valid. The data is little-endian (byte at the offset in bits 7:0), and lanes above the access size are zero. Length code 1 reads one byte, 2 reads two and any other code reads four. A four-byte read at an offset above 0xFC is served as a two-byte read, and a two-byte read above 0xFE as a one-byte read. Misses are excluded from this fallback.
- R3: A write stores data byte n (bits 8n+7:8n) at offset+n, for n below the access size. Bytes that would fall past offset 0xFF are dropped.
- R4: With HDR_TYPE 0x00 or 0x80, ordinary byte writes leave these offsets unchanged: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x2C-0x33 and 0x3D.
- R5: With any other HDR_TYPE (bridge layout), ordinary byte writes leave these offsets unchanged: 0x00-0x03, 0x08-0x0B, 0x0E, 0x2C-0x2F, 0x38-0x3B and 0x3D. Offsets 0x10-0x27 and 0x30-0x33 are writable.
- R6: A four-byte write at an offset in 0x10-0x27 selects region index (offset-0x10)>>2. If that region is implemented (size exponent non-zero), the write bypasses the read-only map. It stores (data AND NOT(size-1)) OR the region's 4-bit type in the four bytes from the offset.
- R7: A four-byte write at an offset in 0x30-0x33, with a non-zero ROM size exponent, bypasses the map. It stores data AND (NOT(size-1) OR 1), which keeps the aligned address bits and the enable bit 0.
- R8: Writes clear the CMD_HI_RSVD bits of offset 0x05, the STAT_LO_RSVD bits of offset 0x06 and the STAT_HI_RSVD bits of offset 0x07 (defaults 0xF8, 0x07, 0x06).
- R9: In the bridge layout, sec_bus always shows the byte at offset 0x19, which is updated by a byte write at 0x19 or by a wider write starting at 0x18. In the endpoint layout, sec_bus is 0.
- R10: Reset loads VENDOR_ID at 0x00-0x01, DEVICE_ID at 0x02-0x03, CLASS_CODE at 0x09-0x0B and HDR_TYPE at 0x0E. It loads each implemented region's type into the low byte of its base register and clears every other byte.
- R11: remap_req is high for exactly the cycle after a write that changes the stored value of any byte at 0x04-0x05, 0x10-0x27 or 0x30-0x33. It is low otherwise, including after writes that store the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 24 | Bus, device/function, register offset |
| acc_len | input | 3 | Length code: 1, 2, other = 4 bytes |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| remap_req | output | 1 | One-cycle pulse on command or base address change |
| sec_bus | output | 8 | Stored secondary bus number (bridge layout) |

## Verification
Assertions check several properties on every cycle. Locked bytes never move, missed reads return the all-ones pattern, and missed writes leave the whole image unchanged. The reserved command and status bits stay clear, every implemented endpoint base register keeps its type in the bits below its size, and a remap pulse only ever follows a hitting write. Other behaviour can only be shown by the bench scenarios, which drive an endpoint instance and a bridge instance side by side. These scenarios cover the exact values returned by sizing reads, the read fallback near the top of the space, write truncation at 0xFF, the difference between the two read-only maps, the secondary bus update, and remap pulses being suppressed when a rewrite stores the same value.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
   localparam int CFG_BYTES = 256;
   localparam int NUM_BARS  = 6;

   typedef enum logic [1:0] {
      ACC_B = 2'd0,
      ACC_W = 2'd1,
      ACC_D = 2'd2
   } acc_size_e;

   typedef logic [CFG_BYTES-1:0][7:0] cfg_image_t;

   function automatic acc_size_e size_of_len(input logic [2:0] len);
      case (len)
         3'd1:    return ACC_B;
         3'd2:    return ACC_W;
         default: return ACC_D;
      endcase
   endfunction

   // Locked bytes for ordinary (non base-address-path) writes.
   function automatic logic ro_byte(input logic bridge, input int unsigned a);
      logic common;
      common = (a <= 3) || (a >= 8 && a <= 11) || (a == 14) ||
               (a >= 'h2C && a <= 'h2F) || (a == 'h3D);
      if (bridge)
         return common || (a >= 'h38 && a <= 'h3B);
      return common || (a >= 'h10 && a <= 'h27) || (a >= 'h30 && a <= 'h33);
   endfunction

   // Bytes whose change requests a remap of the decode windows.
   function automatic logic remap_byte(input int unsigned a);
      return (a == 4) || (a == 5) || (a >= 'h10 && a <= 'h27) ||
             (a >= 'h30 && a <= 'h33);
   endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
   parameter logic [7:0] BUS_NUM = 8'h00,
   parameter logic [7:0] DEVFN   = 8'h18
) (
   input  logic [23:0] addr,
   output logic        hit,
   output logic [7:0]  offset
);
   assign hit    = (addr[23:16] == BUS_NUM) && (addr[15:8] == DEVFN);
   assign offset = addr[7:0];
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import cfg_space_pkg::*;
(
   input  cfg_image_t  image,
   input  logic        hit,
   input  logic [7:0]  offset,
   input  acc_size_e   size,
   output logic [31:0] rdata
);
   acc_size_e  eff;
   logic [7:0] b0, b1, b2, b3;

   always_comb begin
      eff = size;
      if (eff == ACC_D && offset > 8'hFC) eff = ACC_W;
      if (eff == ACC_W && offset > 8'hFE) eff = ACC_B;
      b0 = image[offset];
      b1 = image[offset + 8'd1];
      b2 = image[offset + 8'd2];
      b3 = image[offset + 8'd3];
      case (eff)
         ACC_B:   rdata = {24'd0, b0};
         ACC_W:   rdata = {16'd0, b1, b0};
         default: rdata = {b3, b2, b1, b0};
      endcase
      if (!hit) begin
         case (size)
            ACC_B:   rdata = 32'h0000_00FF;
            ACC_W:   rdata = 32'h0000_FFFF;
            default: rdata = 32'hFFFF_FFFF;
         endcase
      end
   end
endmodule

// File: rtl/cfg_write_path.sv
module cfg_write_path
   import cfg_space_pkg::*;
#(
   parameter logic                    BRIDGE       = 1'b0,
   parameter logic [6*NUM_BARS-1:0]   BAR_SZ_LOG2  = '0,
   parameter logic [4*NUM_BARS-1:0]   BAR_TYPE     = '0,
   parameter logic [5:0]              ROM_SZ_LOG2  = 6'd0,
   parameter logic [7:0]              CMD_HI_RSVD  = 8'hF8,
   parameter logic [7:0]              STAT_LO_RSVD = 8'h07,
   parameter logic [7:0]              STAT_HI_RSVD = 8'h06
) (
   input  logic                 we,
   input  logic [7:0]           offset,
   input  acc_size_e            size,
   input  logic [31:0]          wdata,
   output logic [CFG_BYTES-1:0] byte_we,
   output cfg_image_t           byte_wd
);
   logic        bar_win, rom_win, bar_path;
   logic [7:0]  bar_rel;
   logic [2:0]  bar_idx;
   logic [5:0]  sel_log2;
   logic [3:0]  sel_type;
   logic [31:0] sz_mask, bar_val;
   logic [2:0]  nbytes;

   always_comb begin
      bar_win  = (offset >= 8'h10) && (offset < 8'h28);
      rom_win  = (offset >= 8'h30) && (offset < 8'h34);
      bar_rel  = offset - 8'h10;
      bar_idx  = bar_rel[4:2];
      sel_log2 = '0;
      sel_type = '0;
      for (int i = 0; i < NUM_BARS; i++) begin
         if (bar_win && bar_idx == 3'(i)) begin
            sel_log2 = BAR_SZ_LOG2[6*i +: 6];
            sel_type = BAR_TYPE[4*i +: 4];
         end
      end
      if (rom_win) sel_log2 = ROM_SZ_LOG2;
      bar_path = (size == ACC_D) && (bar_win || rom_win) && (sel_log2 != 6'd0);
      sz_mask  = 32'hFFFF_FFFF << sel_log2;
      bar_val  = rom_win ? (wdata & (sz_mask | 32'h1))
                         : ((wdata & sz_mask) | {28'd0, sel_type});
      case (size)
         ACC_B:   nbytes = 3'd1;
         ACC_W:   nbytes = 3'd2;
         default: nbytes = 3'd4;
      endcase
   end

   for (genvar a = 0; a < CFG_BYTES; a++) begin : g_lane
      localparam logic       LOCKED = ro_byte(BRIDGE, a);
      localparam logic [7:0] RSVD   = (a == 5) ? CMD_HI_RSVD  :
                                      (a == 6) ? STAT_LO_RSVD :
                                      (a == 7) ? STAT_HI_RSVD : 8'h00;
      logic [8:0]  rel;
      logic        in_span;
      logic [31:0] src;
      assign rel     = 9'(a) - {1'b0, offset};
      assign in_span = (9'(a) >= {1'b0, offset}) && (rel < {6'd0, nbytes});
      assign src     = bar_path ? bar_val : wdata;
      assign byte_wd[a] = src[{rel[1:0], 3'b000} +: 8] & ~RSVD;
      assign byte_we[a] = we && in_span && (bar_path || !LOCKED);
   end
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
   import cfg_space_pkg::*;
#(
   parameter logic [7:0]              BUS_NUM      = 8'h00,
   parameter logic [7:0]              DEVFN        = 8'h18,
   parameter logic [15:0]             VENDOR_ID    = 16'h1D0F,
   parameter logic [15:0]             DEVICE_ID    = 16'hC0DE,
   parameter logic [23:0]             CLASS_CODE   = 24'h020000,
   parameter logic [7:0]              HDR_TYPE     = 8'h00,
   parameter logic [6*NUM_BARS-1:0]   BAR_SZ_LOG2  = {6'd0, 6'd0, 6'd0, 6'd0, 6'd8, 6'd12},
   parameter logic [4*NUM_BARS-1:0]   BAR_TYPE     = {4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0},
   parameter logic [5:0]              ROM_SZ_LOG2  = 6'd11,
   parameter logic [7:0]              CMD_HI_RSVD  = 8'hF8,
   parameter logic [7:0]              STAT_LO_RSVD = 8'h07,
   parameter logic [7:0]              STAT_HI_RSVD = 8'h06
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_valid,
   input  logic        acc_write,
   input  logic [23:0] acc_addr,
   input  logic [2:0]  acc_len,
   input  logic [31:0] acc_wdata,
   output logic        rd_valid,
   output logic [31:0] rd_data,
   output logic        remap_req,
   output logic [7:0]  sec_bus
);
   localparam logic IS_BRIDGE = !((HDR_TYPE == 8'h00) || (HDR_TYPE == 8'h80));

   function automatic cfg_image_t build_reset_image();
      cfg_image_t img;
      img = '0;
      img[0]  = VENDOR_ID[7:0];
      img[1]  = VENDOR_ID[15:8];
      img[2]  = DEVICE_ID[7:0];
      img[3]  = DEVICE_ID[15:8];
      img[9]  = CLASS_CODE[7:0];
      img[10] = CLASS_CODE[15:8];
      img[11] = CLASS_CODE[23:16];
      img[14] = HDR_TYPE;
      for (int i = 0; i < NUM_BARS; i++)
         if (BAR_SZ_LOG2[6*i +: 6] != 6'd0)
            img[16 + 4*i] = {4'h0, BAR_TYPE[4*i +: 4]};
      return img;
   endfunction

   localparam cfg_image_t RST_IMG = build_reset_image();

   // Elaboration-time parameter checks
   for (genvar i = 0; i < NUM_BARS; i++) begin : g_chk_bar
      if (BAR_SZ_LOG2[6*i +: 6] > 6'd31) begin : g_bad
         $error("region size exponent out of range");
      end
   end
   if (ROM_SZ_LOG2 > 6'd31) begin : g_bad_rom
      $error("ROM size exponent out of range");
   end

   logic                 hit;
   logic [7:0]           offset;
   acc_size_e            size;
   logic                 wr_fire;
   logic [CFG_BYTES-1:0] byte_we;
   cfg_image_t           byte_wd;
   cfg_image_t           cfg_q;
   logic [31:0]          rdata_c;
   logic                 remap_d;

   assign size    = size_of_len(acc_len);
   assign wr_fire = acc_valid && acc_write && hit;

   cfg_addr_decode #(
      .BUS_NUM (BUS_NUM),
      .DEVFN   (DEVFN)
   ) u_dec (
      .addr    (acc_addr),
      .hit     (hit),
      .offset  (offset)
   );

   cfg_write_path #(
      .BRIDGE       (IS_BRIDGE),
      .BAR_SZ_LOG2  (BAR_SZ_LOG2),
      .BAR_TYPE     (BAR_TYPE),
      .ROM_SZ_LOG2  (ROM_SZ_LOG2),
      .CMD_HI_RSVD  (CMD_HI_RSVD),
      .STAT_LO_RSVD (STAT_LO_RSVD),
      .STAT_HI_RSVD (STAT_HI_RSVD)
   ) u_wr (
      .we      (wr_fire),
      .offset  (offset),
      .size    (size),
      .wdata   (acc_wdata),
      .byte_we (byte_we),
      .byte_wd (byte_wd)
   );

   cfg_read_mux u_rd (
      .image  (cfg_q),
      .hit    (hit),
      .offset (offset),
      .size   (size),
      .rdata  (rdata_c)
   );

   always_comb begin
      remap_d = 1'b0;
      for (int a = 0; a < CFG_BYTES; a++)
         if (byte_we[a] && remap_byte(a) && (byte_wd[a] != cfg_q[a]))
            remap_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= RST_IMG;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         remap_req <= 1'b0;
      end else begin
         for (int a = 0; a < CFG_BYTES; a++)
            if (byte_we[a]) cfg_q[a] <= byte_wd[a];
         rd_valid  <= acc_valid && !acc_write;
         if (acc_valid && !acc_write) rd_data <= rdata_c;
         remap_req <= remap_d;
      end
   end

   if (IS_BRIDGE) begin : g_sec_bridge
      assign sec_bus = cfg_q[8'h19];
   end else begin : g_sec_none
      assign sec_bus = 8'h00;
   end

   // ---------------- assertions ----------------
   p_miss_read_ones_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && !hit) |=>
         rd_data == (($past(acc_len) == 3'd1) ? 32'h0000_00FF :
                     ($past(acc_len) == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF))
      else $error("R1 missed read not all ones");

   p_miss_write_inert_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !hit) |=> $stable(cfg_q))
      else $error("R1 missed write altered the image");

   // R4 (endpoint map) and R5 (bridge map): locked bytes outside the base windows never move
   for (genvar a = 0; a < CFG_BYTES; a++) begin : g_lock_chk
      if (ro_byte(IS_BRIDGE, a) && !(a >= 'h10 && a <= 'h27) && !(a >= 'h30 && a <= 'h33)) begin : g_on
         p_locked_stable_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            $stable(cfg_q[a]))
            else $error("R4/R5 locked byte changed");
      end
   end

   if (!IS_BRIDGE) begin : g_bar_chk
      for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
         localparam logic [5:0] LG = BAR_SZ_LOG2[6*i +: 6];
         if (LG != 6'd0) begin : g_on
            p_bar_low_bits_r6 : assert property (@(posedge clk) disable iff (!rst_n)
               (({cfg_q[19+4*i], cfg_q[18+4*i], cfg_q[17+4*i], cfg_q[16+4*i]}
                 & ~(32'hFFFF_FFFF << LG)) == {28'd0, BAR_TYPE[4*i +: 4]}))
               else $error("R6 base register low bits differ from type");
         end
      end
   end

   p_rsvd_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_q[5] & CMD_HI_RSVD) == 8'h00) && ((cfg_q[6] & STAT_LO_RSVD) == 8'h00) &&
      ((cfg_q[7] & STAT_HI_RSVD) == 8'h00))
      else $error("R8 reserved bit set");

   p_remap_after_write_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      remap_req |-> $past(acc_valid && acc_write && hit))
      else $error("R11 remap pulse without write");
endmodule

// File: tb/sim_cfg_space_regfile.sv
`timescale 1ns/1ps
module sim_cfg_space_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [23:0] acc_addr = '0;
   logic [2:0]  acc_len = 3'd4;
   logic [31:0] acc_wdata = '0;

   logic [1:0]       rv, rm;
   logic [1:0][31:0] rdd;
   logic [1:0][7:0]  sb;

   always #2.5 clk = ~clk;

   cfg_space_regfile u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
      .rd_valid(rv[0]), .rd_data(rdd[0]), .remap_req(rm[0]), .sec_bus(sb[0]));

   cfg_space_regfile #(
      .DEVICE_ID(16'hB21D), .CLASS_CODE(24'h060400), .HDR_TYPE(8'h01)
   ) u1 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
      .rd_valid(rv[1]), .rd_data(rdd[1]), .remap_req(rm[1]), .sec_bus(sb[1]));

   int errors = 0;
   int checks = 0;
   bit chk_en = 0;
   bit done = 0;
   string cur_tag = "R10";

   // ---------------- reference model ----------------
   logic [7:0]  mdl [2][256];
   bit          exp_rv [2];
   logic [31:0] exp_rd [2];
   bit          exp_rm [2];

   function automatic bit m_locked(int k, int a);
      bit c;
      c = (a inside {[0:3], [8:11], 14, [44:47], 61});
      if (k == 1) return c || (a inside {[56:59]});
      return c || (a inside {[16:39], [48:51]});
   endfunction

   function automatic int m_bar_log2(int idx);
      case (idx) 0: return 12; 1: return 8; default: return 0; endcase
   endfunction

   function automatic logic [7:0] m_rsvd(int a);
      case (a) 5: return 8'hF8; 6: return 8'h07; 7: return 8'h06; default: return 8'h00; endcase
   endfunction

   task automatic m_reset();
      for (int k = 0; k < 2; k++) begin
         for (int a = 0; a < 256; a++) mdl[k][a] = 8'h00;
         mdl[k][0] = 8'h0F; mdl[k][1] = 8'h1D;
         mdl[k][20] = 8'h01;
      end
      mdl[0][2] = 8'hDE; mdl[0][3] = 8'hC0; mdl[0][11] = 8'h02;
      mdl[1][2] = 8'h1D; mdl[1][3] = 8'hB2; mdl[1][10] = 8'h04; mdl[1][11] = 8'h06;
      mdl[1][14] = 8'h01;
   endtask

   function automatic bit m_hit(logic [23:0] ad);
      return ad[23:16] == 8'h00 && ad[15:8] == 8'h18;
   endfunction

   task automatic m_write(int k, int off, int len, logic [31:0] d, output bit rmp);
      int n; bit barp; logic [31:0] v; logic [7:0] b; int lg;
      n = (len == 1) ? 1 : (len == 2) ? 2 : 4;
      barp = 0; v = d;
      if (n == 4 && off >= 16 && off < 40) begin
         lg = m_bar_log2((off - 16) / 4);
         if (lg != 0) begin
            barp = 1;
            v = (d & ~((32'd1 << lg) - 1)) | ((((off - 16) / 4) == 1) ? 32'd1 : 32'd0);
         end
      end
      if (n == 4 && off >= 48 && off < 52) begin
         barp = 1;
         v = d & (~((32'd1 << 11) - 1) | 32'd1);
      end
      rmp = 0;
      for (int i = 0; i < n; i++) begin
         int a;
         a = off + i;
         if (a > 255) break;
         if (barp || !m_locked(k, a)) begin
            b = v[8*i +: 8] & ~m_rsvd(a);
            if ((a inside {4, 5, [16:39], [48:51]}) && b != mdl[k][a]) rmp = 1;
            mdl[k][a] = b;
         end
      end
   endtask

   function automatic logic [31:0] m_read(int k, bit h, int off, int len);
      int n; logic [31:0] r;
      if (!h) return (len == 1) ? 32'hFF : (len == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
      n = (len == 1) ? 1 : (len == 2) ? 2 : 4;
      if (n == 4 && off > 252) n = 2;
      if (n == 2 && off > 254) n = 1;
      r = '0;
      for (int i = 0; i < n; i++) r[8*i +: 8] = mdl[k][off + i];
      return r;
   endfunction

   // ---------------- per-clock comparison ----------------
   task automatic check(int k, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s u%0d %s: actual %h expected %h", cur_tag, k, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (chk_en && !done) begin
         for (int k = 0; k < 2; k++) begin
            check(k, "rd_valid", {31'd0, rv[k]}, {31'd0, exp_rv[k]});
            if (exp_rv[k]) check(k, "rd_data", rdd[k], exp_rd[k]);
            check(k, "remap_req", {31'd0, rm[k]}, {31'd0, exp_rm[k]});
            check(k, "sec_bus", {24'd0, sb[k]}, (k == 1) ? {24'd0, mdl[1][25]} : 32'd0);
         end
      end
   end

   task automatic access(bit wr, logic [23:0] ad, logic [2:0] len, logic [31:0] d, string tag);
      bit rmp;
      cur_tag = tag;
      acc_valid = 1'b1; acc_write = wr; acc_addr = ad; acc_len = len; acc_wdata = d;
      for (int k = 0; k < 2; k++) begin
         exp_rv[k] = !wr;
         exp_rm[k] = 0;
         if (wr) begin
            if (m_hit(ad)) begin
               m_write(k, int'(ad[7:0]), int'(len), d, rmp);
               exp_rm[k] = rmp;
            end
         end else begin
            exp_rd[k] = m_read(k, m_hit(ad), int'(ad[7:0]), int'(len));
         end
      end
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
      for (int k = 0; k < 2; k++) begin exp_rv[k] = 0; exp_rm[k] = 0; end
   endtask

   task automatic rd(logic [7:0] off, logic [2:0] len, string tag);
      access(1'b0, {16'h0018, off}, len, 32'h0, tag);
   endtask

   task automatic wr(logic [7:0] off, logic [2:0] len, logic [31:0] d, string tag);
      access(1'b1, {16'h0018, off}, len, d, tag);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_reset();
      for (int k = 0; k < 2; k++) begin exp_rv[k] = 0; exp_rm[k] = 0; exp_rd[k] = '0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_en = 1;

      // R10: reset image
      rd(8'h00, 3'd4, "R10");
      rd(8'h08, 3'd4, "R10");
      rd(8'h0E, 3'd1, "R10");
      rd(8'h10, 3'd4, "R10");
      rd(8'h14, 3'd4, "R10");
      rd(8'h40, 3'd4, "R10");

      // R1: missed bus / slot
      access(1'b0, 24'h01_18_00, 3'd1, 32'h0, "R1");
      access(1'b0, 24'h00_20_00, 3'd2, 32'h0, "R1");
      access(1'b0, 24'h00_19_00, 3'd4, 32'h0, "R1");
      access(1'b1, 24'h02_18_40, 3'd4, 32'hDEAD_BEEF, "R1");
      rd(8'h40, 3'd4, "R1");

      // R2 / R3: byte-lane order, sizes
      wr(8'h40, 3'd4, 32'hA1B2_C3D4, "R3");
      rd(8'h40, 3'd4, "R2");
      rd(8'h41, 3'd1, "R2");
      rd(8'h42, 3'd2, "R2");
      rd(8'h40, 3'd3, "R2");
      wr(8'h44, 3'd2, 32'hFFFF_5A6B, "R3");
      rd(8'h44, 3'd4, "R3");

      // R3: truncation at top, R2 fallback
      wr(8'hFE, 3'd4, 32'h1122_3344, "R3");
      rd(8'hFC, 3'd4, "R3");
      rd(8'hFE, 3'd4, "R2");
      rd(8'hFF, 3'd2, "R2");
      rd(8'h00, 3'd4, "R3");

      // R4 / R5: read-only maps
      wr(8'h00, 3'd4, 32'h1234_5678, "R4");
      rd(8'h00, 3'd4, "R4");
      wr(8'h3C, 3'd4, 32'h7788_99AA, "R4");
      rd(8'h3C, 3'd4, "R4");
      wr(8'h10, 3'd2, 32'h0000_ABCD, "R5");
      rd(8'h10, 3'd4, "R5");
      wr(8'h38, 3'd4, 32'hCAFE_F00D, "R5");
      rd(8'h38, 3'd4, "R5");
      wr(8'h2C, 3'd4, 32'h5555_AAAA, "R4");
      rd(8'h2C, 3'd4, "R4");

      // R6: sizing reads
      wr(8'h10, 3'd4, 32'hFFFF_FFFF, "R6");
      rd(8'h10, 3'd4, "R6");
      wr(8'h14, 3'd4, 32'hFFFF_FFFF, "R6");
      rd(8'h14, 3'd4, "R6");
      wr(8'h10, 3'd4, 32'hE000_1234, "R6");
      rd(8'h10, 3'd4, "R6");
      wr(8'h1C, 3'd4, 32'h1357_9BDF, "R6");
      rd(8'h1C, 3'd4, "R6");

      // R7: expansion ROM register
      wr(8'h30, 3'd4, 32'hFFFF_FFFF, "R7");
      rd(8'h30, 3'd4, "R7");
      wr(8'h30, 3'd4, 32'h1234_5670, "R7");
      rd(8'h30, 3'd4, "R7");

      // R8 + R11: command/status reserved bits and remap pulses
      wr(8'h04, 3'd4, 32'hFFFF_FFFF, "R8");
      rd(8'h04, 3'd4, "R8");
      wr(8'h04, 3'd4, 32'hFFFF_FFFF, "R11");
      wr(8'h05, 3'd1, 32'h0000_0000, "R11");
      wr(8'h06, 3'd2, 32'h0000_0000, "R11");
      wr(8'h14, 3'd4, 32'h0000_2301, "R11");
      wr(8'h14, 3'd4, 32'h0000_2301, "R11");

      // R9: secondary bus number
      wr(8'h19, 3'd1, 32'h0000_0033, "R9");
      rd(8'h18, 3'd4, "R9");
      wr(8'h18, 3'd2, 32'h0000_4400, "R9");
      wr(8'h18, 3'd4, 32'h0012_5501, "R9");
      rd(8'h18, 3'd4, "R9");

      repeat (3) @(negedge clk);
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule